// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing slave of a 4 KB serial EEPROM. It oversamples the two-wire clock and data lines with the system clock and finds start and stop conditions. It accepts a device byte whose upper nibble is a fixed type code, followed by three strap bits and a read/write bit. On a write, it takes a two-byte word address and passes each data byte to a page buffer port. On a read, it fetches bytes from a synchronous memory read port and shifts them out. The data line is open drain: the engine only asserts an output-enable that pulls the line low.

A single address counter serves both directions. After any byte is accessed, the counter points at the next location. A current-address read uses the counter as it stands. A random read first loads the counter with a dummy write, then sends a repeated start. Read addresses wrap over the whole array. Write addresses wrap inside a 32-byte page. A stop that ends a write with at least one accepted byte raises a one-cycle program request.

While the program sequencer reports busy, the engine stays idle and leaves its address unacknowledged, so masters can poll for completion. With the protect input high, writes to the upper half of the array are refused at the data byte.

States:
- `S_IDLE`: waits for a start.
- `S_DEV` → `S_DEV_ACK`: device byte and its acknowledge.
- `S_ADH` → `S_ADH_ACK`: high address byte and its acknowledge.
- `S_ADL` → `S_ADL_ACK`: low address byte and its acknowledge.
- `S_WDAT` ↔ `S_WDAT_ACK`: data byte and its acknowledge, repeated for each byte.
- `S_RLOAD` → `S_RCAP` → `S_RSEND` → `S_RACK`: read fetch, capture, eight bits out, then the master's acknowledge.

Transitions:
- Stop from any state goes to `S_IDLE`.
- Start from any state, when not busy, goes to `S_DEV`.
- Device mismatch goes to `S_IDLE`.
- From `S_DEV_ACK`, a read goes to `S_RLOAD` and a write goes to `S_ADH`.
- A protected data byte goes to `S_IDLE`.
- In `S_RACK`, a master acknowledge goes to `S_RLOAD` and a master NACK goes to `S_IDLE`.

Top module: `ee2w_slave`

## Requirements
- R1: After reset, the engine releases SDA (`sda_oe`=0), with no write strobe and no program request.
- R2: The device byte is received MSB first. Bits 7:4 must be 1010, bits 3:1 must equal `strap`, and bit 0 is R/W (1 = read). Only a matching byte is acknowledged on the ninth clock.
- R3: In a write, the low nibble of the first address byte gives address bits 11:8, and its upper nibble is ignored. The second byte gives bits 7:0. Both bytes are acknowledged.
- R4: Each accepted write data byte is acknowledged and produces a one-cycle `wr_valid`, carrying the current address and the byte.
- R5: A stop that follows at least one accepted data byte pulses `pgm_req` once. A stop after an address-only write does not.
- R6: A random read (dummy write of the address, repeated start, read device byte) returns the byte stored at that address.
- R7: A current-address read returns the byte at the last accessed address plus one.
- R8: A read continues with the next address while the master acknowledges, wrapping from 0xFFF to 0x000. After a master NACK, SDA is released.
- R9: Successive write bytes increment only the low 5 address bits, wrapping within the 32-byte page.
- R10: With `wp` high and address bit 11 set, both address bytes are acknowledged and the data byte is not. No `wr_valid` and no `pgm_req` follow, and memory is unchanged.
- R11: While `busy` is high, a start is ignored and the device byte is not acknowledged.
- R12: A start in the middle of a byte restarts reception of a device byte. The partial byte is discarded.
- R13: The engine changes `sda_oe` only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap | input | 3 | Device select straps |
| wp | input | 1 | Protect upper half when high |
| busy | input | 1 | Program cycle in progress |
| wr_valid | output | 1 | Write byte strobe to page buffer |
| wr_addr | output | 12 | Write byte address |
| wr_data | output | 8 | Write byte |
| pgm_req | output | 1 | One-cycle program request on stop |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 12 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |

## Verification
Every internal slip shows on the wire within one byte.
- A wrong bit counter shifts the acknowledge by one clock. The master then sees a NACK or a corrupted byte at the very next ninth clock.
- A wrong address counter shows up in the first byte of a current-address or sequential read.
- A bad page or array wrap shows up three bytes later, when the data read back differs.
- A missed protect or busy decision shows as an unexpected acknowledge or `wr_valid`, in the same byte slot.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_DEV_ACK, S_ADH, S_ADH_ACK, S_ADL, S_ADL_ACK,
        S_WDAT, S_WDAT_ACK, S_RLOAD, S_RCAP, S_RSEND, S_RACK
    } st_t;
endpackage

// File: rtl/ee2w_sync.sv
module ee2w_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pipe[s] <= '1;
                else if (s == 0)
                    pipe[s] <= d;
                else
                    pipe[s] <= pipe[(s > 0) ? s - 1 : 0];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ee2w_cond.sv
module ee2w_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter int AW          = 12,
    parameter int PAGE_BYTES  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [2:0]    strap,
    input  logic          wp,
    input  logic          busy,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          pgm_req,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int HW = AW - 8;

    logic [1:0] bus_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    ee2w_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
    );
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    ee2w_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    st_t           st, nxt;
    logic [3:0]    cnt;
    logic [7:0]    shreg, txreg;
    logic [HW-1:0] hi_q;
    logic [AW-1:0] addr;
    logic          rw, m_ack, wr_pend;
    logic          byte_done, dev_hit, wp_block;

    assign byte_done = scl_fall && (cnt == 4'd8);
    assign dev_hit   = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap) && !busy;
    assign wp_block  = wp && addr[AW-1];

    // next state
    always_comb begin
        nxt = st;
        if (stop_ev)
            nxt = S_IDLE;
        else if (start_ev && !busy)
            nxt = S_DEV;
        else begin
            unique case (st)
                S_IDLE:     nxt = S_IDLE;
                S_DEV:      if (byte_done) nxt = dev_hit ? S_DEV_ACK : S_IDLE;
                S_DEV_ACK:  if (scl_fall)  nxt = rw ? S_RLOAD : S_ADH;
                S_ADH:      if (byte_done) nxt = S_ADH_ACK;
                S_ADH_ACK:  if (scl_fall)  nxt = S_ADL;
                S_ADL:      if (byte_done) nxt = S_ADL_ACK;
                S_ADL_ACK:  if (scl_fall)  nxt = S_WDAT;
                S_WDAT:     if (byte_done) nxt = wp_block ? S_IDLE : S_WDAT_ACK;
                S_WDAT_ACK: if (scl_fall)  nxt = S_WDAT;
                S_RLOAD:    nxt = S_RCAP;
                S_RCAP:     nxt = S_RSEND;
                S_RSEND:    if (scl_fall && cnt == 4'd7) nxt = S_RACK;
                S_RACK:     if (scl_fall)  nxt = m_ack ? S_RLOAD : S_IDLE;
                default:    nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            txreg    <= '1;
            hi_q     <= '0;
            addr     <= '0;
            rw       <= 1'b0;
            m_ack    <= 1'b0;
            wr_pend  <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            pgm_req  <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            pgm_req  <= 1'b0;
            if (stop_ev) begin
                pgm_req <= wr_pend;
                wr_pend <= 1'b0;
            end else if (start_ev && !busy) begin
                cnt <= '0;
            end else begin
                unique case (st)
                    S_DEV, S_ADH, S_ADL, S_WDAT: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end
                        if (byte_done) begin
                            if (st == S_DEV) rw <= shreg[0];
                            if (st == S_ADH) hi_q <= shreg[HW-1:0];
                            if (st == S_ADL) addr <= {hi_q, shreg};
                            if (st == S_WDAT && !wp_block) begin
                                wr_valid <= 1'b1;
                                wr_addr  <= addr;
                                wr_data  <= shreg;
                                wr_pend  <= 1'b1;
                                addr     <= {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
                            end
                        end
                    end
                    S_DEV_ACK, S_ADH_ACK, S_ADL_ACK, S_WDAT_ACK:
                        if (scl_fall) cnt <= '0;
                    S_RCAP: begin
                        txreg <= rd_data;
                        addr  <= addr + 1'b1;
                        cnt   <= '0;
                    end
                    S_RSEND:
                        if (scl_fall) begin
                            txreg <= {txreg[6:0], 1'b1};
                            cnt   <= cnt + 4'd1;
                        end
                    S_RACK:
                        if (scl_rise) m_ack <= !sda_s;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        rd_en  = 1'b0;
        unique case (st)
            S_DEV_ACK, S_ADH_ACK, S_ADL_ACK, S_WDAT_ACK: sda_oe = 1'b1;
            S_RSEND: sda_oe = ~txreg[7];
            S_RLOAD: rd_en  = 1'b1;
            default: ;
        endcase
    end

    assign rd_addr = addr;
endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk
    import ee2w_pkg::*;
#(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          sda_oe,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic          wp,
    input logic          busy,
    input st_t           st,
    input logic          pgm_req,
    input logic          stop_ev
);
    assert_sda_steady_scl_high_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    assert_wr_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    assert_no_protected_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wp) |-> !wr_addr[AW-1]);

    assert_busy_holds_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st == S_IDLE) |=> st == S_IDLE);

    assert_pgm_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_req |-> $past(stop_ev));
endmodule

bind ee2w_slave ee2w_slave_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wp(wp), .busy(busy),
    .st(st), .pgm_req(pgm_req), .stop_ev(stop_ev)
);

// File: tb/tb_ee2w_slave.sv
`timescale 1ns/1ps
module tb_ee2w_slave;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic        sda_oe, wr_valid, pgm_req, rd_en;
    logic [11:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic [2:0]  strap = 3'b101;
    logic        wp = 1'b0, busy = 1'b0;
    wire         sda_line = m_sda & ~sda_oe;

    int total = 0, bad = 0;
    int wr_cnt = 0, pgm_cnt = 0;
    logic [11:0] last_wa;
    logic [7:0]  last_wd;
    logic [7:0]  mem [4096];

    localparam logic [7:0] DW = 8'hAA;  // 1010_101_0
    localparam logic [7:0] DR = 8'hAB;

    ee2w_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap(strap), .wp(wp), .busy(busy), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .pgm_req(pgm_req), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] f(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]};
    endfunction

    initial for (int i = 0; i < 4096; i++) mem[i] = f(12'(i));

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
        if (wr_valid) begin
            mem[wr_addr] <= wr_data;
            wr_cnt  <= wr_cnt + 1;
            last_wa <= wr_addr;
            last_wd <= wr_data;
        end
        if (pgm_req) pgm_cnt <= pgm_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic hw; repeat (20) @(negedge clk); endtask

    task automatic bstart;
        m_sda = 1'b1; hw; m_scl = 1'b1; hw; m_sda = 1'b0; hw; m_scl = 1'b0; hw;
    endtask
    task automatic bstop;
        m_sda = 1'b0; hw; m_scl = 1'b1; hw; m_sda = 1'b1; hw;
    endtask
    task automatic bit_out(input logic b);
        m_sda = b; hw; m_scl = 1'b1; hw; m_scl = 1'b0; hw;
    endtask
    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_sda = 1'b1; hw; m_scl = 1'b1; hw; ack = !sda_line; m_scl = 1'b0; hw;
    endtask
    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw; m_scl = 1'b1; hw; b[i] = sda_line; m_scl = 1'b0;
        end
        hw; m_sda = !mack; hw; m_scl = 1'b1; hw; m_scl = 1'b0; hw; m_sda = 1'b1;
    endtask

    task automatic set_addr(input logic [7:0] h, input logic [7:0] l);
        logic a;
        bstart;
        send_byte(DW, a); chk(a, "R2 dev ack", a, 1);
        send_byte(h, a);  chk(a, "R3 hi ack", a, 1);
        send_byte(l, a);  chk(a, "R3 lo ack", a, 1);
    endtask

    task automatic t_reset;
        chk(sda_oe == 0 && wr_valid == 0 && pgm_req == 0, "R1 reset", {sda_oe, wr_valid, pgm_req}, 0);
    endtask

    task automatic t_bad_addr;
        logic a;
        bstart; send_byte(8'hA0, a); chk(!a, "R2 wrong strap nack", a, 0); bstop;
        bstart; send_byte(8'h2B, a); chk(!a, "R2 wrong type nack", a, 0); bstop;
    endtask

    task automatic t_byte_write;
        logic a; int p0;
        p0 = pgm_cnt;
        set_addr(8'hF1, 8'h23);
        send_byte(8'hA5, a); chk(a, "R4 data ack", a, 1);
        chk(last_wa == 12'h123, "R3 upper nibble ignored", last_wa, 12'h123);
        chk(last_wd == 8'hA5, "R4 data", last_wd, 8'hA5);
        bstop; hw;
        chk(pgm_cnt == p0 + 1, "R5 pgm once", pgm_cnt, p0 + 1);
    endtask

    task automatic t_random_read;
        logic a; logic [7:0] d; int p0;
        p0 = pgm_cnt;
        set_addr(8'h01, 8'h23);
        bstart; send_byte(DR, a); chk(a, "R6 read dev ack", a, 1);
        recv_byte(1'b0, d); chk(d == 8'hA5, "R6 random read", d, 8'hA5);
        bstop; hw;
        chk(pgm_cnt == p0, "R5 no pgm on dummy write", pgm_cnt, p0);
        bstart; send_byte(DR, a);
        recv_byte(1'b0, d); chk(d == f(12'h124), "R7 current read", d, f(12'h124));
        bstop;
    endtask

    task automatic t_seq_wrap;
        logic a; logic [7:0] d;
        set_addr(8'h0F, 8'hFE);
        bstart; send_byte(DR, a);
        recv_byte(1'b1, d); chk(d == f(12'hFFE), "R8 seq 0", d, f(12'hFFE));
        recv_byte(1'b1, d); chk(d == f(12'hFFF), "R8 seq 1", d, f(12'hFFF));
        recv_byte(1'b0, d); chk(d == f(12'h000), "R8 wrap", d, f(12'h000));
        hw; chk(sda_oe == 0, "R8 released after nack", sda_oe, 0);
        bstop;
    endtask

    task automatic t_page;
        logic a; logic [7:0] d;
        set_addr(8'h00, 8'h3E);
        send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
        chk(last_wa == 12'h020, "R9 page wrap addr", last_wa, 12'h020);
        bstop;
        set_addr(8'h00, 8'h3E);
        bstart; send_byte(DR, a);
        recv_byte(1'b1, d); chk(d == 8'h11, "R9 byte 3E", d, 8'h11);
        recv_byte(1'b1, d); chk(d == 8'h22, "R9 byte 3F", d, 8'h22);
        recv_byte(1'b0, d); chk(d == f(12'h040), "R9 040 untouched", d, f(12'h040));
        bstop;
        set_addr(8'h00, 8'h20);
        bstart; send_byte(DR, a);
        recv_byte(1'b0, d); chk(d == 8'h33, "R9 byte 020", d, 8'h33);
        bstop;
    endtask

    task automatic t_wp;
        logic a; logic [7:0] d; int p0, w0;
        wp = 1'b1; p0 = pgm_cnt; w0 = wr_cnt;
        set_addr(8'h08, 8'h10);
        send_byte(8'h5A, a); chk(!a, "R10 data nack", a, 0);
        bstop; hw;
        chk(pgm_cnt == p0 && wr_cnt == w0, "R10 no write", pgm_cnt + wr_cnt, p0 + w0);
        set_addr(8'h08, 8'h10);
        bstart; send_byte(DR, a);
        recv_byte(1'b0, d); chk(d == f(12'h810), "R10 mem kept", d, f(12'h810));
        bstop;
        set_addr(8'h02, 8'h34);
        send_byte(8'h77, a); chk(a, "R10 lower half ack", a, 1);
        bstop; hw;
        chk(pgm_cnt == p0 + 1, "R10 lower half pgm", pgm_cnt, p0 + 1);
        wp = 1'b0;
    endtask

    task automatic t_busy;
        logic a;
        busy = 1'b1;
        bstart; send_byte(DW, a); chk(!a, "R11 busy nack", a, 0); bstop;
        busy = 1'b0;
        bstart; send_byte(DW, a); chk(a, "R11 ready ack", a, 1); bstop;
    endtask

    task automatic t_restart;
        logic a; logic [7:0] d; int w0;
        w0 = wr_cnt;
        set_addr(8'h00, 8'h50);
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        bstart; send_byte(DR, a); chk(a, "R12 restart dev ack", a, 1);
        recv_byte(1'b0, d); chk(d == f(12'h050), "R12 read after restart", d, f(12'h050));
        bstop; hw;
        chk(wr_cnt == w0, "R12 partial byte dropped", wr_cnt, w0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_bad_addr;
        t_byte_write;
        t_random_read;
        t_seq_wrap;
        t_page;
        t_wp;
        t_busy;
        t_restart;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule